// File: doc/BRIEF.md
# Paired-Word Floating-Point Register File

This block stores the floating-point architectural state of a processor as 32 words of 32 bits. The same storage serves both precisions: a single-precision access touches one word, and a double-precision access at index n treats word n as the low half and word n+1 as the high half of one 64-bit value. There are no separate 64-bit registers. A double written at n is therefore visible word by word at n and n+1, and the reverse also holds.

The block has one write port and two independent read ports. Each port takes a 2-bit access mode and a 5-bit index. Besides the full 32-bit and 64-bit accesses, the mode can select only the upper half of the 64-bit view at n. A read can return that half on its own, and a write can replace it without touching the lower half. A move into the lower half alone is a plain 32-bit write at n. The storage is split internally into an even bank and an odd bank, so that a 64-bit access that starts at either parity completes in one cycle. Read results are registered. A synchronous clear input zeroes the whole file.

Top module: `fprf`

## Requirements
- R1: While `rst` is high at a clock edge, every storage word is zeroed, and `rd0_data`, `rd1_data`, `rd0_err`, `rd1_err` and `wr_err` read 0 after that edge.
- R2: Mode 2'b00 (single word) writes `wr_data[31:0]` into word n only. A read in this mode returns word n in bits [31:0], with bits [63:32] zero.
- R3: Mode 2'b01 (pair) writes `wr_data[31:0]` into word n and `wr_data[63:32]` into word n+1. A read in this mode returns {word n+1, word n}. Both hold for odd n as well as even n.
- R4: Mode 2'b10 (upper half) on a read returns word n+1 in bits [31:0], with bits [63:32] zero.
- R5: Mode 2'b10 on a write stores `wr_data[31:0]` into word n+1 and leaves word n unchanged.
- R6: A pair or upper-half access at the last index (31) sets that port's error flag one cycle later. A read returns zero data, and a write changes no word.
- R7: Mode 2'b11 is illegal on every port. It sets the port's error flag and returns zero data, and a write in this mode changes no word.
- R8: `clr` high at a clock edge zeroes every word and takes priority over a write in the same cycle. A read in that cycle still returns the contents from before the clear.
- R9: Read data appears one cycle after the request. A write is seen by a read requested in the following cycle. A read of the word being written in the same cycle returns the old value.
- R10: The two read ports operate independently and at the same time, each with its own mode and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all storage |
| wr_en | input | 1 | Write request |
| wr_mode | input | 2 | Write access mode (00 word, 01 pair, 10 upper half, 11 illegal) |
| wr_idx | input | 5 | Write word index n |
| wr_data | input | 64 | Write data |
| wr_err | output | 1 | Registered error for the previous write request |
| rd0_mode | input | 2 | Read port 0 access mode |
| rd0_idx | input | 5 | Read port 0 word index |
| rd0_data | output | 64 | Read port 0 registered data |
| rd0_err | output | 1 | Read port 0 registered error |
| rd1_mode | input | 2 | Read port 1 access mode |
| rd1_idx | input | 5 | Read port 1 word index |
| rd1_data | output | 64 | Read port 1 registered data |
| rd1_err | output | 1 | Read port 1 registered error |

## Verification
Directed sequences write a single word, then a pair at an odd index, and read them back through both widths on both ports. This separates correct bank steering from a design that only handles even-aligned pairs. An upper-half write placed over an existing low word shows whether the low half survives, and same-cycle write/read and clear/write pairs pin down the read-old ordering and the clear priority. Index 31 in pair and upper modes and the illegal mode code exercise the error path, including a readback that proves no word moved. A long stretch of random modes, indices, data and occasional clears is then compared every cycle against a word-array model, which catches mixed-parity aliasing that the directed cases miss.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

  typedef enum logic [1:0] {
    ACC_WORD  = 2'b00,
    ACC_PAIR  = 2'b01,
    ACC_UPPER = 2'b10,
    ACC_BAD   = 2'b11
  } acc_mode_e;

endpackage

// File: rtl/fprf_steer.sv
module fprf_steer
  import fprf_pkg::*;
#(
  parameter int IDX_W = 5,
  localparam int ROW_W = IDX_W - 1
) (
  input  logic             req_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       mode_i,
  output logic [ROW_W-1:0] even_row_o,
  output logic [ROW_W-1:0] odd_row_o,
  output logic             even_sel_o,
  output logic             odd_sel_o,
  output logic             lo_odd_o,
  output logic             err_o
);

  logic             need_lo;
  logic             need_hi;
  logic             bad;
  logic             at_last;
  logic             ok;
  logic [IDX_W-1:0] idx_up;

  always_comb begin
    need_lo = (mode_i == ACC_WORD) || (mode_i == ACC_PAIR);
    need_hi = (mode_i == ACC_PAIR) || (mode_i == ACC_UPPER);
    bad     = (mode_i == ACC_BAD);
  end

  assign at_last = &idx_i;
  assign err_o   = req_i & (bad | (need_hi & at_last));
  assign ok      = req_i & ~err_o;
  assign idx_up  = idx_i + 1'b1;

  // the word at n lives in bank n[0]; the word at n+1 lives in the other bank
  assign lo_odd_o   = idx_i[0];
  assign odd_row_o  = idx_i[IDX_W-1:1];
  assign even_row_o = idx_i[0] ? idx_up[IDX_W-1:1] : idx_i[IDX_W-1:1];
  assign even_sel_o = ok & (idx_i[0] ? need_hi : need_lo);
  assign odd_sel_o  = ok & (idx_i[0] ? need_lo : need_hi);

endmodule

// File: rtl/fprf_bank.sv
module fprf_bank #(
  parameter int ROWS   = 16,
  parameter int WORD_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ROW_W-1:0]  ra0,
  input  logic [ROW_W-1:0]  ra1,
  output logic [WORD_W-1:0] rq0,
  output logic [WORD_W-1:0] rq1
);

  logic [ROWS-1:0][WORD_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mem <= '0;
    end else if (we) begin
      mem[wrow] <= wdata;
    end
  end

  assign rq0 = mem[ra0];
  assign rq1 = mem[ra1];

  assert_clear_zero_R8 : assert property (@(posedge clk) disable iff (rst)
    clr |=> (mem == '0));

  assert_hold_when_idle_R6 : assert property (@(posedge clk) disable iff (rst)
    (!we && !clr) |=> $stable(mem));

  assert_write_lands_R2 : assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |=> (mem[$past(wrow)] == $past(wdata)));

endmodule

// File: rtl/fprf.sv
module fprf
  import fprf_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int ROW_W    = IDX_W - 1,
  localparam int ROWS     = NUM_WORDS / 2,
  localparam int DW       = 2 * WORD_W,
  localparam int NRD      = 2,
  localparam int NACC     = NRD + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [1:0]       wr_mode,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic             wr_err,
  input  logic [1:0]       rd0_mode,
  input  logic [IDX_W-1:0] rd0_idx,
  output logic [DW-1:0]    rd0_data,
  output logic             rd0_err,
  input  logic [1:0]       rd1_mode,
  input  logic [IDX_W-1:0] rd1_idx,
  output logic [DW-1:0]    rd1_data,
  output logic             rd1_err
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  // accessor 0 is the write port, accessors 1..NRD are the read ports
  logic [IDX_W-1:0] acc_idx  [NACC];
  logic [1:0]       acc_mode [NACC];
  logic             acc_req  [NACC];

  assign acc_idx[0]  = wr_idx;
  assign acc_mode[0] = wr_mode;
  assign acc_req[0]  = wr_en;
  assign acc_idx[1]  = rd0_idx;
  assign acc_mode[1] = rd0_mode;
  assign acc_req[1]  = 1'b1;
  assign acc_idx[2]  = rd1_idx;
  assign acc_mode[2] = rd1_mode;
  assign acc_req[2]  = 1'b1;

  logic [ROW_W-1:0] s_row    [NACC][2];
  logic             s_sel    [NACC][2];
  logic             s_lo_odd [NACC];
  logic             s_err    [NACC];

  for (genvar a = 0; a < NACC; a++) begin : g_steer
    fprf_steer #(.IDX_W(IDX_W)) u_steer (
      .req_i      (acc_req[a]),
      .idx_i      (acc_idx[a]),
      .mode_i     (acc_mode[a]),
      .even_row_o (s_row[a][0]),
      .odd_row_o  (s_row[a][1]),
      .even_sel_o (s_sel[a][0]),
      .odd_sel_o  (s_sel[a][1]),
      .lo_odd_o   (s_lo_odd[a]),
      .err_o      (s_err[a])
    );
  end

  // write data split: the upper-half mode takes its word from the low lane
  logic [WORD_W-1:0] wr_lo;
  logic [WORD_W-1:0] wr_hi;

  assign wr_lo = wr_data[WORD_W-1:0];
  assign wr_hi = (wr_mode == ACC_UPPER) ? wr_data[WORD_W-1:0] : wr_data[DW-1:WORD_W];

  logic [WORD_W-1:0] bank_q [2][NRD];
  logic              bank_we [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] wd;

    assign wd         = ((b == 1) == s_lo_odd[0]) ? wr_lo : wr_hi;
    assign bank_we[b] = s_sel[0][b];

    fprf_bank #(.ROWS(ROWS), .WORD_W(WORD_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .we    (bank_we[b]),
      .wrow  (s_row[0][b]),
      .wdata (wd),
      .ra0   (s_row[1][b]),
      .ra1   (s_row[2][b]),
      .rq0   (bank_q[b][0]),
      .rq1   (bank_q[b][1])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [WORD_W-1:0] q_even;
    logic [WORD_W-1:0] q_odd;
    logic [WORD_W-1:0] lo_w;
    logic [WORD_W-1:0] hi_w;
    logic [DW-1:0]     nxt;
    logic [DW-1:0]     data_q;
    logic              err_q;

    assign q_even = s_sel[p+1][0] ? bank_q[0][p] : '0;
    assign q_odd  = s_sel[p+1][1] ? bank_q[1][p] : '0;
    assign lo_w   = s_lo_odd[p+1] ? q_odd  : q_even;
    assign hi_w   = s_lo_odd[p+1] ? q_even : q_odd;
    assign nxt    = (acc_mode[p+1] == ACC_UPPER) ? {{WORD_W{1'b0}}, hi_w} : {hi_w, lo_w};

    always_ff @(posedge clk) begin
      if (rst) begin
        data_q <= '0;
        err_q  <= 1'b0;
      end else begin
        data_q <= nxt;
        err_q  <= s_err[p+1];
      end
    end

    assert_err_zero_R7 : assert property (@(posedge clk) disable iff (rst)
      err_q |-> (data_q == '0));

    assert_upper_zero_R4 : assert property (@(posedge clk) disable iff (rst)
      (acc_mode[p+1] == ACC_UPPER) |=> (data_q[DW-1:WORD_W] == '0));
  end

  logic wr_err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_err_q <= 1'b0;
    end else begin
      wr_err_q <= s_err[0];
    end
  end

  assign wr_err   = wr_err_q;
  assign rd0_data = g_rd[0].data_q;
  assign rd0_err  = g_rd[0].err_q;
  assign rd1_data = g_rd[1].data_q;
  assign rd1_err  = g_rd[1].err_q;

  assert_pair_last_err_R6 : assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mode == ACC_PAIR && wr_idx == LAST_IDX) |=> wr_err);

  assert_word_one_bank_R2 : assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mode == ACC_WORD) |-> ($countones({bank_we[1], bank_we[0]}) == 1));

endmodule

// File: tb/fprf_bench.sv
`timescale 1ns/1ps
module fprf_bench;

  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_mode = 2'b00;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        wr_err;
  logic [1:0]  rd0_mode = 2'b00;
  logic [4:0]  rd0_idx = '0;
  logic [63:0] rd0_data;
  logic        rd0_err;
  logic [1:0]  rd1_mode = 2'b00;
  logic [4:0]  rd1_idx = '0;
  logic [63:0] rd1_data;
  logic        rd1_err;

  always #2.5 clk = ~clk;

  fprf u_fprf (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
    .rd0_mode(rd0_mode), .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_mode(rd1_mode), .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_err(rd1_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit armed = 0;
  string cur_tag = "R1";

  logic [31:0] model [N];
  logic [63:0] exp_d0, exp_d1;
  bit          exp_e0, exp_e1, exp_we;
  string       tag0, tag1, tagw;

  function automatic logic [63:0] ref_read(input logic [1:0] m, input int n, output bit e);
    e = 0;
    if (m == 2'b11 || (m != 2'b00 && n == N-1)) begin
      e = 1;
      return '0;
    end
    case (m)
      2'b00:   return {32'h0, model[n]};
      2'b01:   return {model[n+1], model[n]};
      default: return {32'h0, model[n+1]};
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] m, input int n);
    if (cur_tag != "") return cur_tag;
    if (m == 2'b11) return "R7";
    if (m != 2'b00 && n == N-1) return "R6";
    if (m == 2'b00) return "R2";
    if (m == 2'b01) return "R3";
    return "R4";
  endfunction

  // reference model: expected outputs formed from inputs and pre-edge state
  always @(posedge clk) begin
    if (rst) begin
      exp_d0 = '0; exp_d1 = '0; exp_e0 = 0; exp_e1 = 0; exp_we = 0;
      tag0 = cur_tag; tag1 = cur_tag; tagw = cur_tag;
      for (int i = 0; i < N; i++) model[i] = '0;
    end else begin
      bit werr;
      exp_d0 = ref_read(rd0_mode, int'(rd0_idx), exp_e0);
      exp_d1 = ref_read(rd1_mode, int'(rd1_idx), exp_e1);
      tag0 = mode_tag(rd0_mode, int'(rd0_idx));
      tag1 = mode_tag(rd1_mode, int'(rd1_idx));
      werr = wr_en && (wr_mode == 2'b11 || (wr_mode != 2'b00 && wr_idx == 5'd31));
      exp_we = werr;
      tagw = (cur_tag != "") ? cur_tag : ((wr_mode == 2'b11) ? "R7" : "R6");
      if (clr) begin
        for (int i = 0; i < N; i++) model[i] = '0;
      end else if (wr_en && !werr) begin
        case (wr_mode)
          2'b00: model[wr_idx] = wr_data[31:0];
          2'b01: begin
            model[wr_idx]   = wr_data[31:0];
            model[wr_idx+1] = wr_data[63:32];
          end
          default: model[wr_idx+1] = wr_data[31:0];
        endcase
      end
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (rd0_data !== exp_d0 || rd0_err !== exp_e0) begin
        errors++;
        $display("FAIL %s port0: got data=%h err=%b expected data=%h err=%b",
                 tag0, rd0_data, rd0_err, exp_d0, exp_e0);
      end
      checks++;
      if (rd1_data !== exp_d1 || rd1_err !== exp_e1) begin
        errors++;
        $display("FAIL %s port1: got data=%h err=%b expected data=%h err=%b",
                 tag1, rd1_data, rd1_err, exp_d1, exp_e1);
      end
      checks++;
      if (wr_err !== exp_we) begin
        errors++;
        $display("FAIL %s write error flag: got %b expected %b", tagw, wr_err, exp_we);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] m, input logic [4:0] n, input logic [63:0] d);
    wr_en = 1; wr_mode = m; wr_idx = n; wr_data = d;
  endtask

  task automatic rd(input int port, input logic [1:0] m, input logic [4:0] n);
    if (port == 0) begin rd0_mode = m; rd0_idx = n; end
    else begin rd1_mode = m; rd1_idx = n; end
  endtask

  task automatic quiet();
    wr_en = 0; clr = 0; rd(0, 2'b00, 5'd0); rd(1, 2'b00, 5'd1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_tag = "R1";
    repeat (3) tick();
    rst = 0;
    tick();
    tick();

    // R2 and R3, including a pair that starts at an odd index
    cur_tag = "";
    wr(2'b00, 5'd3, 64'hFFFF_FFFF_1111_0003);
    tick();
    wr(2'b01, 5'd5, 64'hAAAA_0006_BBBB_0005);
    rd(0, 2'b00, 5'd3);
    tick();
    wr_en = 0;
    rd(0, 2'b01, 5'd5); rd(1, 2'b00, 5'd6);
    tick();
    // R4: upper half read
    rd(0, 2'b10, 5'd5); rd(1, 2'b01, 5'd4);
    tick();

    // R5: upper-half write keeps the low word
    cur_tag = "R5";
    wr(2'b00, 5'd10, 64'h0000_0000_C0DE_0010);
    tick();
    wr(2'b10, 5'd10, 64'hDEAD_DEAD_F00D_0011);
    tick();
    wr_en = 0;
    rd(0, 2'b01, 5'd10); rd(1, 2'b00, 5'd11);
    tick();
    rd(0, 2'b00, 5'd10); rd(1, 2'b10, 5'd10);
    tick();

    // R6: wide or upper access at the last index
    cur_tag = "R6";
    wr(2'b00, 5'd31, 64'h0000_0000_3131_3131);
    tick();
    wr(2'b01, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(0, 2'b01, 5'd31); rd(1, 2'b10, 5'd31);
    tick();
    wr(2'b10, 5'd31, 64'h0000_0000_5555_5555);
    tick();
    wr_en = 0;
    rd(0, 2'b00, 5'd31); rd(1, 2'b00, 5'd0);
    tick();

    // R7: illegal mode code
    cur_tag = "R7";
    wr(2'b11, 5'd12, 64'h1234_5678_9ABC_DEF0);
    rd(0, 2'b11, 5'd12); rd(1, 2'b11, 5'd3);
    tick();
    wr_en = 0;
    rd(0, 2'b00, 5'd12); rd(1, 2'b00, 5'd13);
    tick();

    // R9: same-cycle write/read returns the old value, next cycle sees the new one
    cur_tag = "R9";
    wr(2'b00, 5'd20, 64'h0000_0000_0000_0001);
    rd(0, 2'b00, 5'd20);
    tick();
    wr(2'b00, 5'd20, 64'h0000_0000_0000_0002);
    tick();
    wr_en = 0;
    tick();

    // R8: clear beats a same-cycle write; same-cycle read sees old data
    cur_tag = "R8";
    wr(2'b00, 5'd7, 64'h0000_0000_0000_0077);
    tick();
    clr = 1;
    wr(2'b00, 5'd8, 64'h0000_0000_0000_0088);
    rd(0, 2'b00, 5'd7); rd(1, 2'b01, 5'd5);
    tick();
    clr = 0; wr_en = 0;
    rd(0, 2'b00, 5'd7); rd(1, 2'b00, 5'd8);
    tick();

    // R10: both ports at once with different modes
    cur_tag = "R10";
    wr(2'b01, 5'd2, 64'h2222_0003_1111_0002);
    tick();
    wr_en = 0;
    rd(0, 2'b01, 5'd2); rd(1, 2'b10, 5'd2);
    tick();
    rd(0, 2'b10, 5'd1); rd(1, 2'b00, 5'd3);
    tick();

    // random traffic compared against the word model every cycle
    cur_tag = "";
    for (int k = 0; k < 4000; k++) begin
      wr_en   = ($urandom_range(0, 9) < 7);
      wr_mode = 2'($urandom_range(0, 3));
      wr_idx  = 5'($urandom_range(0, 31));
      wr_data = {$urandom, $urandom};
      clr     = ($urandom_range(0, 63) == 0);
      rd(0, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)));
      rd(1, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)));
      tick();
    end
    quiet();
    tick();
    tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule